// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block runs the bus cycles that move a small 8-bit processor with a 16-bit address bus from its current instruction stream into an interrupt service routine. It samples a pending request only when the opcode-fetch strobe marks an instruction boundary. If it accepts the request, it captures the program counter, the status byte, the stack pointer, the stack-page select and the vector address. It then runs a fixed six-cycle bus program: one dummy read, three stack writes, and two vector reads. The return state is pushed, and the vector gives the new program counter.

Arbitration and the instruction decoder sit outside the block. `irq_pend` is already the enabled winner, and `vec_base` is the vector address for that winner. The bus has no back-pressure. Every cycle is a single clock, and read data must be valid in the same cycle that `bus_rd` is high. Sequencing and status pins are plain levels or pulses. When the sequence finishes, the block presents the new program counter, the new stack pointer and the updated status byte for one `done` cycle. The values stay held after that cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block drives `bus_rd`=0, `bus_wr`=0, `busy`=0, `done`=0, `pc_out`=0, `sp_out`=0 and `psr_out`=0.
- R2: A request is accepted only on a clock edge where `sync`=1, `irq_pend`=1 and `busy`=0. With `sync` alone, or with `irq_pend` alone, no bus cycle starts.
- R3: The cycle that follows acceptance is a dummy read. In it `bus_rd`=1, `bus_wr`=0 and `bus_addr` equals the captured PC. The data returned in this cycle is discarded.
- R4: The next three cycles are writes (`bus_wr`=1, `bus_rd`=0). They write PC[15:8] to stack offset S, then PC[7:0] to S-1, then the captured status byte to S-2, where S is the captured stack pointer.
- R5: The stack write address is {page, low}. The page byte is 0x00 when `stk_page_sel`=0 and 0x01 when `stk_page_sel`=1.
- R6: The low byte of the stack address is computed modulo 256 inside the page. For example, S=0x01 gives 0x01, 0x00 and 0xFF.
- R7: The two cycles after the writes are reads (`bus_rd`=1). The first reads address `vec_base` (AL). The second reads `vec_base`+1 modulo 2^16 (AH).
- R8: `done` is high for exactly the one cycle after the second vector read. In that cycle `pc_out` = {AH, AL}.
- R9: When `done` rises, `sp_out` equals the captured stack pointer minus 3, modulo 256.
- R10: When `done` rises, `psr_out` equals the captured status byte with bit 2 (interrupt disable) set. The pushed status byte is the unmodified original.
- R11: While `busy`=1, `sync` and `irq_pend` are ignored. The sequence is always exactly six bus cycles, and `bus_rd` and `bus_wr` are never high together.
- R12: Changes to `pc_in`, `psr_in`, `sp_in`, `stk_page_sel` and `vec_base` after acceptance do not affect the bus trace or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Opcode-fetch strobe (instruction boundary) |
| irq_pend | input | 1 | Pending, enabled, already-arbitrated request |
| stk_page_sel | input | 1 | Stack page select (0: page 0x00, 1: page 0x01) |
| vec_base | input | 16 | Address of the vector low byte for the winning source |
| pc_in | input | 16 | Current program counter |
| psr_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer (low byte) |
| rd_data | input | 8 | Read data, valid in the same cycle as `bus_rd` |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the new PC is valid |
| pc_out | output | 16 | New program counter {AH, AL} |
| sp_out | output | 8 | Stack pointer after the three pushes |
| psr_out | output | 8 | Status byte with the interrupt-disable bit set |

## Verification
The assertions check the following on every cycle:
- `bus_rd` and `bus_wr` are never high together.
- The cycle after acceptance is a dummy read at the PC that was captured.
- Stack writes stay inside page 0x00 or 0x01.
- Each write that follows another write steps the low address byte down by one with wrap.
- `done` is a single-cycle pulse that directly follows a read.

Only the bench scenarios can show the rest:
- the exact data order of the pushes;
- the vector address pair, including the wrap from 0xFFFF to 0x0000;
- the values of the new PC, the stack pointer and the status byte;
- that inputs changed mid-sequence, and a `sync` pulse mid-sequence, leave the trace untouched.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DUMMY  = 3'd1,
    ST_PUSH_H = 3'd2,
    ST_PUSH_L = 3'd3,
    ST_PUSH_P = 3'd4,
    ST_VEC_L  = 3'd5,
    ST_VEC_H  = 3'd6
  } entry_state_e;

  localparam int unsigned IDIS_BIT = 2;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync,
  input  logic         irq_pend,
  output entry_state_e state,
  output logic         accept,
  output logic         busy
);
  entry_state_e state_d;

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && sync && irq_pend;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (accept) state_d = ST_DUMMY;
      ST_DUMMY:  state_d = ST_PUSH_H;
      ST_PUSH_H: state_d = ST_PUSH_L;
      ST_PUSH_L: state_d = ST_PUSH_P;
      ST_PUSH_P: state_d = ST_VEC_L;
      ST_VEC_L:  state_d = ST_VEC_H;
      ST_VEC_H:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/irq_entry_ctx.sv
module irq_entry_ctx #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic              page_sel_in,
  input  logic [ADDR_W-1:0] vec_in,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] psr_q,
  output logic [SP_W-1:0]   sp_q,
  output logic              page_q,
  output logic [ADDR_W-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      psr_q  <= '0;
      sp_q   <= '0;
      page_q <= 1'b0;
      vec_q  <= '0;
    end else if (accept) begin
      pc_q   <= pc_in;
      psr_q  <= psr_in;
      sp_q   <= sp_in;
      page_q <= page_sel_in;
      vec_q  <= vec_in;
    end
  end
endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
  import irq_entry_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8
) (
  input  entry_state_e      state,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [DATA_W-1:0] psr_q,
  input  logic [SP_W-1:0]   sp_q,
  input  logic              page_q,
  input  logic [ADDR_W-1:0] vec_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr
);
  localparam int unsigned PAGE_W = ADDR_W - SP_W;
  localparam int unsigned HALF_W = ADDR_W / 2;

  logic [PAGE_W-1:0] page_byte;
  logic [SP_W-1:0]   sp_off;

  assign page_byte = {{(PAGE_W-1){1'b0}}, page_q};

  always_comb begin
    unique case (state)
      ST_PUSH_L: sp_off = sp_q - SP_W'(1);
      ST_PUSH_P: sp_off = sp_q - SP_W'(2);
      default:   sp_off = sp_q;
    endcase
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    unique case (state)
      ST_DUMMY: begin
        bus_addr = pc_q;
        bus_rd   = 1'b1;
      end
      ST_PUSH_H: begin
        bus_addr  = {page_byte, sp_off};
        bus_wdata = DATA_W'(pc_q[ADDR_W-1:HALF_W]);
        bus_wr    = 1'b1;
      end
      ST_PUSH_L: begin
        bus_addr  = {page_byte, sp_off};
        bus_wdata = DATA_W'(pc_q[HALF_W-1:0]);
        bus_wr    = 1'b1;
      end
      ST_PUSH_P: begin
        bus_addr  = {page_byte, sp_off};
        bus_wdata = psr_q;
        bus_wr    = 1'b1;
      end
      ST_VEC_L: begin
        bus_addr = vec_q;
        bus_rd   = 1'b1;
      end
      ST_VEC_H: begin
        bus_addr = vec_q + ADDR_W'(1);
        bus_rd   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_result.sv
module irq_entry_result
  import irq_entry_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8,
  parameter int unsigned PUSHES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  entry_state_e      state,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] psr_q,
  input  logic [SP_W-1:0]   sp_q,
  output logic [ADDR_W-1:0] pc_out,
  output logic [SP_W-1:0]   sp_out,
  output logic [DATA_W-1:0] psr_out,
  output logic              done
);
  localparam logic [DATA_W-1:0] IDIS_MASK = DATA_W'(1) << IDIS_BIT;

  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      pc_out  <= '0;
      sp_out  <= '0;
      psr_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_VEC_L) lo_q <= rd_data;
      if (state == ST_VEC_H) begin
        pc_out  <= ADDR_W'({rd_data, lo_q});
        sp_out  <= sp_q - SP_W'(PUSHES);
        psr_out <= psr_q | IDIS_MASK;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              irq_pend,
  input  logic              stk_page_sel,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [SP_W-1:0]   sp_out,
  output logic [DATA_W-1:0] psr_out
);
  entry_state_e      state;
  logic              accept;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] psr_q;
  logic [SP_W-1:0]   sp_q;
  logic              page_q;
  logic [ADDR_W-1:0] vec_q;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync(sync), .irq_pend(irq_pend),
    .state(state), .accept(accept), .busy(busy)
  );

  irq_entry_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .pc_in(pc_in), .psr_in(psr_in), .sp_in(sp_in),
    .page_sel_in(stk_page_sel), .vec_in(vec_base),
    .pc_q(pc_q), .psr_q(psr_q), .sp_q(sp_q), .page_q(page_q), .vec_q(vec_q)
  );

  irq_entry_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_bus (
    .state(state), .pc_q(pc_q), .psr_q(psr_q), .sp_q(sp_q),
    .page_q(page_q), .vec_q(vec_q),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
  );

  irq_entry_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_res (
    .clk(clk), .rst_n(rst_n), .state(state), .rd_data(rd_data),
    .psr_q(psr_q), .sp_q(sp_q),
    .pc_out(pc_out), .sp_out(sp_out), .psr_out(psr_out), .done(done)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync,
  input logic              irq_pend,
  input logic              busy,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] pc_in,
  input logic              done
);
  localparam int unsigned PAGE_W = ADDR_W - SP_W;

  // R11: never read and write in the same cycle
  assert_no_rd_wr_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R3: cycle after acceptance is a dummy read at the captured PC
  assert_dummy_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && irq_pend && !busy) |=> (bus_rd && !bus_wr && bus_addr == $past(pc_in)));

  // R5: stack writes land in page 0x00 or 0x01
  assert_stack_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr[ADDR_W-1:SP_W] <= PAGE_W'(1)));

  // R6: consecutive writes step the low byte down by one with wrap, same page
  assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |->
      (bus_addr[SP_W-1:0] == $past(bus_addr[SP_W-1:0]) - SP_W'(1)) &&
      (bus_addr[ADDR_W-1:SP_W] == $past(bus_addr[ADDR_W-1:SP_W])));

  // R8: done is a single-cycle pulse right after a read
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_rd));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .irq_pend(irq_pend), .busy(busy),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .pc_in(pc_in),
  .done(done)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0, irq_pend = 1'b0, stk_page_sel = 1'b0;
  logic [15:0] vec_base = '0, pc_in = '0;
  logic [7:0]  psr_in = '0, sp_in = '0;
  logic [7:0]  rd_data;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, sp_out, psr_out;
  logic        bus_rd, bus_wr, busy, done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign rd_data = bus_rd ? mem_byte(bus_addr) : 8'h00;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .irq_pend(irq_pend),
    .stk_page_sel(stk_page_sel), .vec_base(vec_base), .pc_in(pc_in),
    .psr_in(psr_in), .sp_in(sp_in), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out), .psr_out(psr_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  psr;
    logic [7:0]  sp;
    logic        page;
    logic [15:0] vec;
  } row_t;

  localparam int NROWS = 5;
  localparam row_t ROWS [NROWS] = '{
    '{pc:16'h1234, psr:8'h00, sp:8'hFF, page:1'b0, vec:16'hFFFA},
    '{pc:16'hABCD, psr:8'hC3, sp:8'h80, page:1'b1, vec:16'hFFF4},
    '{pc:16'h0100, psr:8'h04, sp:8'h01, page:1'b1, vec:16'h2000},  // R6 wrap
    '{pc:16'hFFFF, psr:8'hFB, sp:8'h00, page:1'b0, vec:16'hFFFF},  // R6, R7 wrap
    '{pc:16'h5A5A, psr:8'h81, sp:8'h02, page:1'b0, vec:16'h0010}
  };

  task automatic run_entry(input row_t r);
    logic [15:0] hi_pg, exp_a;
    logic [7:0]  al, ah;
    hi_pg = {7'b0, r.page, 8'h00};
    al = mem_byte(r.vec);
    ah = mem_byte(r.vec + 16'd1);
    @(negedge clk);
    pc_in = r.pc; psr_in = r.psr; sp_in = r.sp;
    stk_page_sel = r.page; vec_base = r.vec;
    sync = 1'b1; irq_pend = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      sync = (k == 3);            // R11: sync mid-sequence is ignored
      pc_in = 16'hDEAD; psr_in = 8'hEE; sp_in = 8'h77;   // R12
      stk_page_sel = ~r.page; vec_base = 16'h4444;
      case (k)
        1: begin
          chk(bus_rd && !bus_wr, "R3 dummy rd/wr", {bus_rd, bus_wr}, 2'b10);
          chk(bus_addr == r.pc, "R3/R12 dummy addr", bus_addr, r.pc);
        end
        2, 3, 4: begin
          exp_a = hi_pg | {8'h00, r.sp - 8'(k - 2)};
          chk(bus_wr && !bus_rd, "R4 push strobes", {bus_rd, bus_wr}, 2'b01);
          chk(bus_addr == exp_a, "R4/R5/R6 push addr", bus_addr, exp_a);
          chk(bus_wdata == (k == 2 ? r.pc[15:8] : k == 3 ? r.pc[7:0] : r.psr),
              "R4/R10 push data", bus_wdata,
              (k == 2 ? r.pc[15:8] : k == 3 ? r.pc[7:0] : r.psr));
        end
        5, 6: begin
          exp_a = r.vec + 16'(k - 5);
          chk(bus_rd && !bus_wr, "R7 vector rd", {bus_rd, bus_wr}, 2'b10);
          chk(bus_addr == exp_a, "R7 vector addr", bus_addr, exp_a);
          chk(!done, "R8 no early done", done, 0);
        end
        7: begin
          chk(done, "R8 done", done, 1);
          chk(pc_out == {ah, al}, "R8 pc_out", pc_out, {ah, al});
          chk(sp_out == r.sp - 8'd3, "R9 sp_out", sp_out, r.sp - 8'd3);
          chk(psr_out == (r.psr | 8'h04), "R10 psr_out", psr_out, r.psr | 8'h04);
          chk(!bus_rd && !bus_wr && !busy, "R11 six cycles", {busy, bus_rd, bus_wr}, 0);
        end
        default: begin
          chk(!done, "R8 done one cycle", done, 0);
          chk(!bus_rd && !bus_wr, "R11 no restart", {bus_rd, bus_wr}, 0);
        end
      endcase
    end
    irq_pend = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_rd && !bus_wr && !busy && !done, "R1 strobes", {bus_rd, bus_wr, busy, done}, 0);
    chk(pc_out == 0 && sp_out == 0 && psr_out == 0, "R1 results",
        {pc_out, sp_out, psr_out}, 0);

    // R2: sync alone, then request alone
    sync = 1'b1; irq_pend = 1'b0;
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr, "R2 sync only", {busy, bus_rd, bus_wr}, 0);
    sync = 1'b0; irq_pend = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr, "R2 irq only", {busy, bus_rd, bus_wr}, 0);
    irq_pend = 1'b0;

    for (int i = 0; i < NROWS; i++) run_entry(ROWS[i]);

    // R2: acceptance right after a finished sequence still works
    run_entry(ROWS[1]);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule